// File: doc/BRIEF.md
# Burst SSRAM Strobe Sequencer

This block drives the five active-low control strobes of an external cache built from synchronous SRAMs. The strobes are address load, data output enable, data write enable, tag output enable and tag write enable. A cache controller asks for a read burst or a write burst. The sequencer then walks through a fixed number of beats, four by default, and puts out the pin levels that suit the SRAM style chosen on a static 2-bit type input. Every strobe leaves the block from a register. A busy level and a one-cycle done pulse report progress back to the controller.

The type input packs two independent choices. Bit 0 set means a bursting SRAM, which takes the address once per burst. Bit 0 clear means a non-bursting part, which needs the address on every beat. Bit 1 clear makes the output-enable pins an asynchronous enable that spans the read data and stays on for one cycle after it. Bit 1 set makes them per-beat chip selects. The resulting codes are 0 = A, 1 = B, 2 = C and 3 = D. Address generation, data steering, forwarded-clock capture and pin timing are handled elsewhere.

Top module: `ssram_strobe_seq`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it, all five strobes are high and busy and done are low.
- R2: A read request accepted in idle yields one all-high lead-in cycle. Four read beats follow, then one closing cycle, then idle. Busy is high from the lead-in through the closing cycle.
- R3: A write request accepted in idle yields four write beats, then one closing cycle, then idle. Busy is high from the first beat through the closing cycle.
- R4: Load is low on the first beat of every burst. On the later beats it is low only when type bit 0 is 0 (non-bursting). It is high in all other cycles.
- R5: For types A and B (type bit 1 = 0), data output enable is low on all four read beats and on the closing cycle of a read. It is high everywhere else.
- R6: For types C and D (type bit 1 = 1), data output enable is low on the four read beats only.
- R7: Tag output enable is low on the first read beat. For types A and B it is also low on the second read beat. It is high everywhere else.
- R8: Data write enable is low on all four write beats. Tag write enable is low on the first write beat only. Neither output enable is ever low during a write beat.
- R9: Done is high for exactly one cycle, the closing cycle that directly follows the last beat.
- R10: Requests that arrive while busy is high are ignored. When read and write are requested together in idle, the read is taken.
- R11: A write beat never directly follows a cycle in which any output enable was low. At least one all-high cycle separates a read from a following write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ram_type_i | input | 2 | SRAM style: bit 0 bursting, bit 1 chip-select OE mode |
| rd_req_i | input | 1 | Read burst request, sampled only when idle |
| wr_req_i | input | 1 | Write burst request, sampled only when idle |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse in the closing cycle |
| sr_load_n_o | output | 1 | Address load strobe, active low |
| sr_doe_n_o | output | 1 | Data output enable or chip select, active low |
| sr_dwe_n_o | output | 1 | Data write enable, active low |
| sr_toe_n_o | output | 1 | Tag output enable or chip select, active low |
| sr_twe_n_o | output | 1 | Tag write enable, active low |

## Verification
The bench builds the block with its default of four beats per burst. That keeps every cycle of every burst short enough to compare in full. It sweeps all four type codes against both burst directions, comparing the whole output vector on every cycle with a table worked out from the requirements. Further runs inject requests in the middle of a burst, request both directions at once, and hold a write request across a read. These runs reach the ignore rule, the read priority and the turnaround gap.

// File: rtl/ssram_seq_pkg.sv
package ssram_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_BEAT = 2'd2,
        PH_TAIL = 2'd3
    } phase_e;

    typedef struct packed {
        logic load_n;
        logic doe_n;
        logic dwe_n;
        logic toe_n;
        logic twe_n;
    } strobes_t;

    localparam strobes_t STROBES_NOP = '1;

endpackage

// File: rtl/ssram_burst_fsm.sv
module ssram_burst_fsm
    import ssram_seq_pkg::*;
#(
    parameter int BEATS = 4,
    localparam int BW   = (BEATS > 2) ? $clog2(BEATS) : 1
) (
    input  phase_e        phase_q,
    input  logic          is_wr_q,
    input  logic [BW-1:0] beat_q,
    input  logic          rd_req,
    input  logic          wr_req,
    output phase_e        phase_d,
    output logic          is_wr_d,
    output logic [BW-1:0] beat_d
);
    localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

    always_comb begin
        phase_d = phase_q;
        is_wr_d = is_wr_q;
        beat_d  = beat_q;
        unique case (phase_q)
            PH_IDLE: begin
                beat_d = '0;
                if (rd_req) begin
                    phase_d = PH_LEAD;
                    is_wr_d = 1'b0;
                end else if (wr_req) begin
                    phase_d = PH_BEAT;
                    is_wr_d = 1'b1;
                end
            end
            PH_LEAD: begin
                phase_d = PH_BEAT;
                beat_d  = '0;
            end
            PH_BEAT: begin
                if (beat_q == LAST_BEAT) begin
                    phase_d = PH_TAIL;
                end else begin
                    beat_d = beat_q + 1'b1;
                end
            end
            PH_TAIL: begin
                phase_d = PH_IDLE;
                beat_d  = '0;
            end
            default: phase_d = PH_IDLE;
        endcase
    end
endmodule

// File: rtl/ssram_strobe_map.sv
module ssram_strobe_map
    import ssram_seq_pkg::*;
#(
    parameter int BEATS = 4,
    localparam int BW   = (BEATS > 2) ? $clog2(BEATS) : 1
) (
    input  logic [1:0]    ram_type,
    input  phase_e        phase,
    input  logic          is_wr,
    input  logic [BW-1:0] beat,
    output strobes_t      pins,
    output logic          busy,
    output logic          done
);
    logic bursting;
    logic cs_mode;
    logic first_beat;
    logic second_beat;

    assign bursting    = ram_type[0];
    assign cs_mode     = ram_type[1];
    assign first_beat  = (beat == '0);
    assign second_beat = (beat == BW'(1));

    always_comb begin
        pins = STROBES_NOP;
        busy = (phase != PH_IDLE);
        done = (phase == PH_TAIL);
        if (phase == PH_BEAT) begin
            pins.load_n = !(first_beat || !bursting);
            if (is_wr) begin
                pins.dwe_n = 1'b0;
                pins.twe_n = !first_beat;
            end else begin
                pins.doe_n = 1'b0;
                pins.toe_n = !(first_beat || (second_beat && !cs_mode));
            end
        end else if (phase == PH_TAIL && !is_wr && !cs_mode) begin
            pins.doe_n = 1'b0;
        end
    end
endmodule

// File: rtl/ssram_strobe_seq.sv
module ssram_strobe_seq
    import ssram_seq_pkg::*;
#(
    parameter int BEATS = 4
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [1:0] ram_type_i,
    input  logic       rd_req_i,
    input  logic       wr_req_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       sr_load_n_o,
    output logic       sr_doe_n_o,
    output logic       sr_dwe_n_o,
    output logic       sr_toe_n_o,
    output logic       sr_twe_n_o
);
    localparam int BW = (BEATS > 2) ? $clog2(BEATS) : 1;

    typedef struct packed {
        phase_e        phase;
        logic          is_wr;
        logic [BW-1:0] beat;
        strobes_t      pins;
        logic          busy;
        logic          done;
    } seq_state_t;

    localparam seq_state_t RESET_STATE = '{
        phase: PH_IDLE, is_wr: 1'b0, beat: '0,
        pins: STROBES_NOP, busy: 1'b0, done: 1'b0
    };

    seq_state_t st_d, st_q;
    phase_e        fsm_phase_d;
    logic          fsm_wr_d;
    logic [BW-1:0] fsm_beat_d;
    strobes_t      map_pins_d;
    logic          map_busy_d;
    logic          map_done_d;

    ssram_burst_fsm #(.BEATS(BEATS)) i_fsm (
        .phase_q (st_q.phase),
        .is_wr_q (st_q.is_wr),
        .beat_q  (st_q.beat),
        .rd_req  (rd_req_i),
        .wr_req  (wr_req_i),
        .phase_d (fsm_phase_d),
        .is_wr_d (fsm_wr_d),
        .beat_d  (fsm_beat_d)
    );

    // Pins are decoded from the next state so that the registered levels line up with the state.
    ssram_strobe_map #(.BEATS(BEATS)) i_map (
        .ram_type (ram_type_i),
        .phase    (fsm_phase_d),
        .is_wr    (fsm_wr_d),
        .beat     (fsm_beat_d),
        .pins     (map_pins_d),
        .busy     (map_busy_d),
        .done     (map_done_d)
    );

    always_comb begin
        st_d       = st_q;
        st_d.phase = fsm_phase_d;
        st_d.is_wr = fsm_wr_d;
        st_d.beat  = fsm_beat_d;
        st_d.pins  = map_pins_d;
        st_d.busy  = map_busy_d;
        st_d.done  = map_done_d;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= RESET_STATE;
        else       st_q <= st_d;
    end

    assign busy_o      = st_q.busy;
    assign done_o      = st_q.done;
    assign sr_load_n_o = st_q.pins.load_n;
    assign sr_doe_n_o  = st_q.pins.doe_n;
    assign sr_dwe_n_o  = st_q.pins.dwe_n;
    assign sr_toe_n_o  = st_q.pins.toe_n;
    assign sr_twe_n_o  = st_q.pins.twe_n;

    AST_RESET_NOP: assert property (@(posedge clk_i)
        $past(rst_i) |-> (&st_q.pins && !busy_o && !done_o)); // R1

    AST_LOAD_IN_BURST: assert property (@(posedge clk_i) disable iff (rst_i)
        !sr_load_n_o |-> busy_o); // R4

    AST_WE_OE_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sr_dwe_n_o || !sr_twe_n_o) |-> (sr_doe_n_o && sr_toe_n_o)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o); // R9

    AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !done_o) |=> busy_o); // R10

    AST_TURNAROUND: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sr_dwe_n_o && $past(sr_dwe_n_o)) |-> ($past(sr_doe_n_o) && $past(sr_toe_n_o))); // R11

endmodule

// File: tb/test_ssram_strobe_seq.sv
`timescale 1ns/1ps
module test_ssram_strobe_seq;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] ram_type;
    logic       rd_req;
    logic       wr_req;
    logic       busy, done, load_n, doe_n, dwe_n, toe_n, twe_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ssram_strobe_seq #(.BEATS(4)) i_ssram_strobe_seq (
        .clk_i       (clk),
        .rst_i       (rst),
        .ram_type_i  (ram_type),
        .rd_req_i    (rd_req),
        .wr_req_i    (wr_req),
        .busy_o      (busy),
        .done_o      (done),
        .sr_load_n_o (load_n),
        .sr_doe_n_o  (doe_n),
        .sr_dwe_n_o  (dwe_n),
        .sr_toe_n_o  (toe_n),
        .sr_twe_n_o  (twe_n)
    );

    // Vector order: busy, done, load_n, doe_n, dwe_n, toe_n, twe_n
    function automatic logic [6:0] expect_vec(input logic [1:0] t, input logic wr, input int s);
        logic b, d, ld, oe, we, toe, twe;
        int beat;
        b = 0; d = 0; ld = 1; oe = 1; we = 1; toe = 1; twe = 1;
        if (!wr) begin
            if (s == 0) b = 1;
            else if (s >= 1 && s <= 4) begin
                beat = s - 1;
                b = 1;
                ld = !(beat == 0 || !t[0]);
                oe = 0;
                toe = !(beat == 0 || (beat == 1 && !t[1]));
            end else if (s == 5) begin
                b = 1; d = 1;
                oe = t[1];
            end
        end else begin
            if (s >= 0 && s <= 3) begin
                beat = s;
                b = 1;
                ld = !(beat == 0 || !t[0]);
                we = 0;
                twe = !(beat == 0);
            end else if (s == 4) begin
                b = 1; d = 1;
            end
        end
        return {b, d, ld, oe, we, toe, twe};
    endfunction

    task automatic check_vec(input logic [6:0] exp, input string tag, input int s);
        logic [6:0] got;
        got = {busy, done, load_n, doe_n, dwe_n, toe_n, twe_n};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s type=%0d slot=%0d actual=%b expected=%b", tag, ram_type, s, got, exp);
        end
    endtask

    // Issues one burst and checks each slot; optionally injects requests while busy.
    task automatic run_burst(input logic [1:0] t, input logic wr, input logic inject);
        int last;
        string tag;
        ram_type = t;
        last = wr ? 6 : 7;
        if (wr) tag = "R3 R4 R8 R9";
        else if (t[1]) tag = "R2 R4 R6 R7 R9";
        else tag = "R2 R4 R5 R7 R9";
        rd_req = !wr;
        wr_req = wr;
        for (int s = 0; s <= last; s++) begin
            @(negedge clk);
            rd_req = 0;
            wr_req = 0;
            if (inject && s == 2) begin
                rd_req = 1;
                wr_req = 1;
            end
            check_vec(expect_vec(t, wr, s), inject ? "R10" : tag, s);
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1; rd_req = 0; wr_req = 0; ram_type = 2'd0;
        repeat (3) @(negedge clk);
        check_vec(7'b0011111, "R1", -1);
        rst = 0;
        @(negedge clk);
        check_vec(7'b0011111, "R1", -1);

        // Full sweep: every type code against both directions
        for (int t = 0; t < 4; t++) begin
            for (int w = 0; w < 2; w++) begin
                run_burst(2'(t), w[0], 1'b0);
            end
        end

        // R10: requests in mid-burst must be ignored
        run_burst(2'd2, 1'b0, 1'b1);
        run_burst(2'd1, 1'b1, 1'b1);

        // R10 priority and R11 turnaround: both requested, write held through the read
        ram_type = 2'd0;
        rd_req = 1; wr_req = 1;
        for (int s = 0; s <= 12; s++) begin
            @(negedge clk);
            rd_req = 0;
            if (s == 7) wr_req = 0;
            if (s <= 5) check_vec(expect_vec(2'd0, 1'b0, s), "R10", s);
            else if (s == 6) check_vec(7'b0011111, "R11", s);
            else check_vec(expect_vec(2'd0, 1'b1, s - 7), "R11", s);
        end

        // R1: reset in mid-burst returns to the idle levels
        rd_req = 1;
        @(negedge clk);
        rd_req = 0;
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        check_vec(7'b0011111, "R1", 0);
        rst = 0;
        @(negedge clk);
        check_vec(7'b0011111, "R1", 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule